// File: doc/BRIEF.md
# Pin-Gated Register Write Lock

This block is a small slice of a runtime register file. It holds two registers: a pin configuration register and a device-disable register. A two-bit function field inside the configuration register can give one external pin a write-protect role. Software selects that role by writing code `01` into the field. After that, software can no longer change the field. Only one of the three reset inputs clears it.

While the role is selected and the synchronized pin is high, bus writes to the device-disable register are dropped. Reads of the register still return its contents. When the pin is low, or the role is not selected, the register behaves as ordinary read/write storage.

The bus is a flat address/data port with a write strobe and a read strobe. Read data is registered and appears on the cycle after the read strobe.

Top module: `pin_lock_regs`

## Requirements
- R1: Each of the three active-high asynchronous resets (`rst_vcc_por`, `rst_vtr_por`, `rst_hard`) clears both registers and `rdata` to 0x00.
- R2: A write strobe at address `CFG_OFFSET` (default 0x10) stores `wdata` into the configuration register when the field is not locked. A later read returns that value.
- R3: The function field occupies bits [SEL_LSB+1:SEL_LSB] (default bits [3:2]), and code `01` selects the write-protect role. Once the field holds `01`, a write cannot change those two bits. The other bits of the configuration register still take the written data.
- R4: A selected write-protect role is cleared only by a reset. Each of the three resets returns the field to `00`.
- R5: The device-disable register sits at address `DIS_OFFSET` (default 0x22). If the role is selected and the synchronized pin is high, a write to it leaves its contents unchanged.
- R6: If the role is selected and the synchronized pin is low, a write to the device-disable register stores `wdata`.
- R7: If the field holds any code other than `01`, the pin level has no effect, and writes to the device-disable register always store `wdata`.
- R8: The pin passes through a synchronizer of `SYNC_STAGES` flops before it gates writes. A pin level held for `SYNC_STAGES`+1 cycles governs every later write.
- R9: A read strobe loads `rdata`, on the next clock edge, with the current value of the addressed register, whatever the pin level. An unmapped address reads 0x00.
- R10: A write to an unmapped address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_vcc_por | input | 1 | Main-supply power-on reset, active high, asynchronous |
| rst_vtr_por | input | 1 | Standby-supply power-on reset, active high, asynchronous |
| rst_hard | input | 1 | Hard reset, active high, asynchronous |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| lock_pin | input | 1 | External pin, asynchronous, non-inverted |
| rdata | output | DATA_W | Registered read data |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default 2. This checks that the settle window follows the parameter and is not fixed at two flops. The offsets stay at their defaults, 0x10 and 0x22, with an 8-bit data width, so the function field sits at bits [3:2].

Random writes, reads, pin changes and resets of each of the three kinds reach every combination of armed field, pin level and address. A reference model in the bench predicts each read.

// File: rtl/pin_lock_pkg.sv
package pin_lock_pkg;
   // function-field codes for the configurable pin
   typedef enum logic [1:0] {
      FN_PLAIN = 2'b00,
      FN_WLOCK = 2'b01,
      FN_ALT_A = 2'b10,
      FN_ALT_B = 2'b11
   } pin_func_e;

   localparam int unsigned FN_W = 2;
endpackage

// File: rtl/pin_lock_sync.sv
module pin_lock_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pin_lock_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[0] <= 1'b0;
            else     chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_lock_cfg.sv
module pin_lock_cfg
   import pin_lock_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned SEL_LSB = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q,
   output logic              armed
);
   localparam int unsigned SEL_MSB = SEL_LSB + FN_W - 1;

   if (SEL_MSB >= DATA_W) begin : g_bad_field
      $error("pin_lock_cfg: function field does not fit in DATA_W");
   end

   logic [DATA_W-1:0] nxt;

   assign armed = (q[SEL_MSB:SEL_LSB] == FN_WLOCK);

   always_comb begin
      nxt = wdata;
      if (armed) nxt[SEL_MSB:SEL_LSB] = FN_WLOCK;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     q <= '0;
      else if (wr) q <= nxt;
   end

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
      armed |=> (q[SEL_MSB:SEL_LSB] == FN_WLOCK)); // R3

   AST_FREE_BITS: assert property (@(posedge clk) disable iff (rst)
      (wr && !armed) |=> (q == $past(wdata))); // R2
endmodule

// File: rtl/pin_lock_dis.sv
module pin_lock_dis #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic              block,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)                q <= '0;
      else if (wr && !block)  q <= wdata;
   end

   AST_DIS_FROZEN: assert property (@(posedge clk) disable iff (rst)
      block |=> $stable(q)); // R5

   AST_DIS_TAKES: assert property (@(posedge clk) disable iff (rst)
      (wr && !block) |=> (q == $past(wdata))); // R6
endmodule

// File: rtl/pin_lock_regs.sv
module pin_lock_regs
   import pin_lock_pkg::*;
#(
   parameter int unsigned    DATA_W      = 8,
   parameter int unsigned    ADDR_W      = 8,
   parameter int unsigned    SEL_LSB     = 2,
   parameter int unsigned    SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h10,
   parameter logic [ADDR_W-1:0] DIS_OFFSET = 8'h22
) (
   input  logic              clk,
   input  logic              rst_vcc_por,
   input  logic              rst_vtr_por,
   input  logic              rst_hard,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              lock_pin,
   output logic [DATA_W-1:0] rdata
);
   if (CFG_OFFSET == DIS_OFFSET) begin : g_bad_map
      $error("pin_lock_regs: register offsets collide");
   end

   logic              rst_any;
   logic              pin_s;
   logic              armed;
   logic              hit_cfg, hit_dis;
   logic              dis_block;
   logic [DATA_W-1:0] cfg_q, dis_q;
   logic [DATA_W-1:0] rd_mux;

   assign rst_any   = rst_vcc_por | rst_vtr_por | rst_hard;
   assign hit_cfg   = (addr == CFG_OFFSET);
   assign hit_dis   = (addr == DIS_OFFSET);
   assign dis_block = armed & pin_s;

   pin_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst_any),
      .d   (lock_pin),
      .q   (pin_s)
   );

   pin_lock_cfg #(.DATA_W(DATA_W), .SEL_LSB(SEL_LSB)) u_cfg (
      .clk   (clk),
      .rst   (rst_any),
      .wr    (wr_en & hit_cfg),
      .wdata (wdata),
      .q     (cfg_q),
      .armed (armed)
   );

   pin_lock_dis #(.DATA_W(DATA_W)) u_dis (
      .clk   (clk),
      .rst   (rst_any),
      .wr    (wr_en & hit_dis),
      .block (dis_block),
      .wdata (wdata),
      .q     (dis_q)
   );

   always_comb begin
      rd_mux = '0;
      if (hit_cfg)      rd_mux = cfg_q;
      else if (hit_dis) rd_mux = dis_q;
   end

   always_ff @(posedge clk or posedge rst_any) begin
      if (rst_any)    rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   AST_READ_DIS: assert property (@(posedge clk) disable iff (rst_any)
      (rd_en && hit_dis) |=> (rdata == $past(dis_q))); // R9

   AST_UNARMED_WRITE: assert property (@(posedge clk) disable iff (rst_any)
      (wr_en && hit_dis && !armed) |=> (dis_q == $past(wdata))); // R7

   AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst_any)
      (wr_en && !hit_cfg && !hit_dis) |=> ($stable(cfg_q) && $stable(dis_q))); // R10
endmodule

// File: tb/pin_lock_regs_test.sv
module pin_lock_regs_test;
   localparam int unsigned DW = 8;
   localparam int unsigned AW = 8;
   localparam int unsigned STG = 3;
   localparam logic [7:0] A_CFG = 8'h10;
   localparam logic [7:0] A_DIS = 8'h22;

   logic          clk = 1'b0;
   logic          rst_vcc_por, rst_vtr_por, rst_hard;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic          wr_en, rd_en, lock_pin;
   logic [DW-1:0] rdata;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] m_cfg, m_dis;

   always #10 clk = ~clk;

   pin_lock_regs #(.SYNC_STAGES(STG), .CFG_OFFSET(A_CFG), .DIS_OFFSET(A_DIS)) uut (
      .clk(clk), .rst_vcc_por(rst_vcc_por), .rst_vtr_por(rst_vtr_por),
      .rst_hard(rst_hard), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .lock_pin(lock_pin), .rdata(rdata)
   );

   function automatic logic is_armed(logic [7:0] c);
      return c[3:2] == 2'b01;
   endfunction

   function automatic logic [7:0] cfg_next(logic [7:0] c, logic [7:0] d);
      logic [7:0] r = d;
      if (is_armed(c)) r[3:2] = 2'b01;
      return r;
   endfunction

   task automatic check(logic [7:0] got, logic [7:0] exp, string req);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic do_write(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == A_CFG)      m_cfg = cfg_next(m_cfg, d);
      else if (a == A_DIS) begin
         if (!(is_armed(m_cfg) && lock_pin)) m_dis = d;
      end
   endtask

   task automatic do_read(logic [7:0] a, string req);
      logic [7:0] e;
      e = (a == A_CFG) ? m_cfg : (a == A_DIS) ? m_dis : 8'h00;
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(rdata, e, req);
   endtask

   task automatic set_pin(logic v);
      @(negedge clk);
      lock_pin = v;
      repeat (STG + 2) @(negedge clk);
   endtask

   task automatic pulse_reset(int which);
      @(negedge clk);
      case (which)
         0: rst_vcc_por = 1'b1;
         1: rst_vtr_por = 1'b1;
         default: rst_hard = 1'b1;
      endcase
      @(negedge clk);
      rst_vcc_por = 1'b0; rst_vtr_por = 1'b0; rst_hard = 1'b0;
      m_cfg = 8'h00; m_dis = 8'h00;
      repeat (STG + 2) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4177));
      rst_vcc_por = 1'b1; rst_vtr_por = 1'b0; rst_hard = 1'b0;
      addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0; lock_pin = 1'b0;
      m_cfg = 8'h00; m_dis = 8'h00;
      repeat (3) @(negedge clk);
      check(rdata, 8'h00, "R1 rdata after reset");
      rst_vcc_por = 1'b0;
      repeat (STG + 2) @(negedge clk);
      do_read(A_CFG, "R1 cfg reset value");
      do_read(A_DIS, "R1 dis reset value");

      // plain storage, unarmed, pin high ignored
      do_write(A_CFG, 8'hA1);
      do_read(A_CFG, "R2 cfg write");
      set_pin(1'b1);
      do_write(A_DIS, 8'h5A);
      do_read(A_DIS, "R7 unarmed pin high writable");

      // arm and try to clear the field
      do_write(A_CFG, 8'h04);
      do_write(A_CFG, 8'hF8);
      do_read(A_CFG, "R3 field sticky other bits written");
      do_write(A_DIS, 8'hC3);
      do_read(A_DIS, "R5 locked write dropped");
      set_pin(1'b0);
      do_write(A_DIS, 8'h3C);
      do_read(A_DIS, "R6 pin low writable");

      // pin rises just before a write: old level still in synchronizer
      @(negedge clk); lock_pin = 1'b1;
      @(negedge clk);
      addr = A_DIS; wdata = 8'h99; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      m_dis = 8'h99;
      repeat (STG + 2) @(negedge clk);
      do_read(A_DIS, "R8 synchronizer latency");
      do_write(A_DIS, 8'h11);
      do_read(A_DIS, "R8 settled pin blocks");
      set_pin(1'b0);

      // each reset clears the lock
      for (int k = 0; k < 3; k++) begin
         do_write(A_CFG, 8'h04);
         pulse_reset(k);
         do_read(A_CFG, "R4 reset clears field");
         do_write(A_CFG, 8'h08);
         do_read(A_CFG, "R4 field writable after reset");
      end

      // stray address
      do_write(A_DIS, 8'h77);
      do_write(8'h30, 8'hFF);
      do_read(A_CFG, "R10 cfg after stray write");
      do_read(A_DIS, "R10 dis after stray write");
      do_read(8'h31, "R9 unmapped reads zero");

      // constrained random
      for (int i = 0; i < 600; i++) begin
         int op;
         op = $urandom_range(0, 19);
         if (op < 5)       do_write(A_CFG, 8'($urandom));
         else if (op < 10) do_write(A_DIS, 8'($urandom));
         else if (op < 11) do_write(8'h40, 8'($urandom));
         else if (op < 14) do_read(A_DIS, "R5 R6 R9 random dis");
         else if (op < 16) do_read(A_CFG, "R3 R9 random cfg");
         else if (op < 19) set_pin(1'($urandom));
         else              pulse_reset($urandom_range(0, 2));
      end
      do_read(A_DIS, "R9 final dis");
      do_read(A_CFG, "R9 final cfg");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule